// File: doc/BRIEF.md
# Half-Integer Clock Divider Branch

This block is one branch of a clock tree. It picks one of several source clocks, passes the chosen clock through a clock gate, and divides it by a half-integer ratio (2N+3)/2. The ratios are 1.5, 2.5, 3.5 and so on. The divider uses state on both edges of the gated clock, so that every output period spans an odd number of input half-periods.

Software configures the branch through a plain 32-bit write port that addresses two 16-bit registers:

- The control register holds the divide field and the source-select field.
- The gate register holds the enable bit.

The write semantics are fixed at build time by a parameter:

- In masked mode, the upper 16 bits of the word say which low bits the write may change. Software can update one field without a read-modify-write.
- In plain mode, the low half of the word replaces the register.

Both registers are read back continuously on output pins. The port is control only, with no back-pressure: a write is accepted on every cfg_clk edge where wr_en is high.

Top module: `hdiv_branch`

## Requirements
- R1: After reset both registers read 0. This means N=0, source 0 selected and the gate disabled, so div_clk stays low with no edges.
- R2: In masked mode, a write changes bit k of the addressed register only if word bit k+16 is 1. In that case bit k takes word bit k. The new value is visible on the readback one cfg_clk edge after the write.
- R3: In plain mode, a write sets the addressed register to word bits [15:0], and the upper half of the word is ignored.
- R4: wr_addr 0 selects the control register and wr_addr 1 selects the gate register. A write to one register leaves the other register unchanged.
- R5: The divide field is control bits [DIV_SHIFT+DIV_W-1:DIV_SHIFT], which is [4:0] by default. A value N makes each div_clk period last exactly 2N+3 half-periods of the selected source.
- R6: Each div_clk high phase lasts N+1 half-periods of the selected source.
- R7: The select field is control bits [MUX_SHIFT+MUX_W-1:MUX_SHIFT], which is bit 8 by default. Its value is the index of the src_clk bit that feeds the branch. With one source, the multiplexer is omitted.
- R8: Gate register bit GATE_BIT (bit 0 by default) enables the branch. The enable is taken on a falling edge of the selected source. When it is clear, div_clk shows no edges; when it is set, the output resumes.
- R9: A new N is adopted only at a frame boundary, which is the div_clk rising edge that starts a group of two output periods. While the value changes, every output period and high phase matches either the old N or the new N.
- R10: In a cycle with no write, both registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | NSRC | Candidate source clocks |
| cfg_clk | input | 1 | Clock of the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset for all state |
| wr_en | input | 1 | Write strobe, sampled on cfg_clk rising edge |
| wr_addr | input | 1 | 0: control register, 1: gate register |
| wr_data | input | 32 | Write word; upper half is the bit mask in masked mode |
| div_clk | output | 1 | Divided clock |
| ctrl_q | output | 16 | Control register readback |
| gate_q | output | 16 | Gate register readback |

## Verification
The readback registers change on the cfg_clk rising edge that samples the write. The bench drives each write on a falling edge and compares both readbacks against its own arithmetic model on the next falling edge.

A divider change reaches div_clk only at the next frame boundary, which is at most two old output periods after the write. The bench therefore lets four div_clk rising edges pass before it timestamps edges, then compares the spacing of those edges with (2N+3) and N+1 source half-periods for every N. Gate and select changes get the same settle interval.

During a change made while the clock runs, every period in the window is checked against the old and new lengths.

// File: rtl/hdiv_pkg.sv
`timescale 1ns/1ps
package hdiv_pkg;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_GATE = 1'b1
  } hdiv_reg_e;

  // Next register value for a write word, under either write mode.
  function automatic logic [15:0] hdiv_merge(input logic [15:0] cur,
                                             input logic [31:0] word,
                                             input logic        masked);
    logic [15:0] keep;
    keep = masked ? word[31:16] : 16'hFFFF;
    return (cur & ~keep) | (word[15:0] & keep);
  endfunction

endpackage

// File: rtl/hdiv_regs.sv
`timescale 1ns/1ps
module hdiv_regs
  import hdiv_pkg::*;
#(
  parameter bit MASKED_WR = 1'b1
) (
  input  logic        cfg_clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  output logic [15:0] ctrl_q,
  output logic [15:0] gate_q
);

  hdiv_reg_e target;
  assign target = hdiv_reg_e'(wr_addr);

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      gate_q <= '0;
    end else if (wr_en) begin
      if (target == REG_CTRL) ctrl_q <= hdiv_merge(ctrl_q, wr_data, MASKED_WR);
      else                    gate_q <= hdiv_merge(gate_q, wr_data, MASKED_WR);
    end
  end

endmodule

// File: rtl/hdiv_srcmux.sv
`timescale 1ns/1ps
module hdiv_srcmux #(
  parameter int NSRC  = 2,
  parameter int MUX_W = 1
) (
  input  logic [NSRC-1:0]  src_clk,
  input  logic [MUX_W-1:0] sel,
  output logic             mux_clk
);

  generate
    if (NSRC == 1) begin : g_single
      assign mux_clk = src_clk[0];
    end else begin : g_multi
      // Out-of-range selects fall back to source 0.
      always_comb begin
        mux_clk = src_clk[0];
        for (int i = 1; i < NSRC; i++) begin
          if (sel == MUX_W'(i)) mux_clk = src_clk[i];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/hdiv_gate.sv
`timescale 1ns/1ps
module hdiv_gate (
  input  logic clk_in,
  input  logic rst_n,
  input  logic en,
  output logic clk_out
);

  logic en_l;

  // Enable retimed while clk_in is low, so a high phase is never cut.
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) en_l <= 1'b0;
    else        en_l <= en;
  end

  assign clk_out = clk_in & en_l;

endmodule

// File: rtl/hdiv_core.sv
`timescale 1ns/1ps
module hdiv_core #(
  parameter int DIV_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     n_cfg,
  output logic                 div_clk,
  output logic [DIV_W+1:0]     cnt_o,
  output logic [DIV_W-1:0]     n_o
);

  // A frame is 2N+3 input cycles = two output periods = 2(2N+3) half-periods.
  localparam int CW = DIV_W + 2;  // counts input cycles in a frame
  localparam int HW = DIV_W + 3;  // indexes half-periods in a frame

  logic [CW-1:0]    cnt, cnt_last, cnt_nxt;
  logic [DIV_W-1:0] n_act;
  logic [HW-1:0]    h_pos, h_neg, ev_fall_a, ev_rise_b, ev_fall_b;
  logic             hit_pos, hit_neg;
  logic             tog_p, tog_n;

  assign cnt_last = CW'({n_act, 1'b0}) + CW'(2);
  assign cnt_nxt  = (cnt == cnt_last) ? '0 : cnt + CW'(1);

  // Output edges within a frame, at half-period indices:
  // rise at 0, fall at N+1, rise at 2N+3, fall at 3N+4.
  assign ev_fall_a = HW'(n_act) + HW'(1);
  assign ev_rise_b = HW'({n_act, 1'b0}) + HW'(3);
  assign ev_fall_b = HW'({n_act, 1'b0}) + HW'(n_act) + HW'(4);

  assign h_pos = HW'({cnt_nxt, 1'b0});  // even index reached at this rising edge
  assign h_neg = HW'({cnt, 1'b1});      // odd index reached at this falling edge

  assign hit_pos = (h_pos == '0) || (h_pos == ev_fall_a) || (h_pos == ev_fall_b);
  assign hit_neg = (h_neg == ev_fall_a) || (h_neg == ev_rise_b) || (h_neg == ev_fall_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= CW'(2);
      n_act <= '0;
      tog_p <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (cnt_nxt == '0) n_act <= n_cfg;
      if (hit_pos) tog_p <= ~tog_p;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)       tog_n <= 1'b0;
    else if (hit_neg) tog_n <= ~tog_n;
  end

  // Only one toggle register changes at any edge.
  assign div_clk = tog_p ^ tog_n;
  assign cnt_o   = cnt;
  assign n_o     = n_act;

endmodule

// File: rtl/hdiv_branch.sv
`timescale 1ns/1ps
module hdiv_branch #(
  parameter int NSRC      = 2,
  parameter bit MASKED_WR = 1'b1,
  parameter int DIV_SHIFT = 0,
  parameter int DIV_W     = 5,
  parameter int MUX_SHIFT = 8,
  parameter int MUX_W     = 1,
  parameter int GATE_BIT  = 0
) (
  input  logic [NSRC-1:0] src_clk,
  input  logic            cfg_clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [31:0]     wr_data,
  output logic            div_clk,
  output logic [15:0]     ctrl_q,
  output logic [15:0]     gate_q
);

  logic [MUX_W-1:0] sel;
  logic [DIV_W-1:0] n_cfg;
  logic             mux_clk;
  logic             gclk;
  logic [DIV_W+1:0] core_cnt;
  logic [DIV_W-1:0] core_n;

  hdiv_regs #(.MASKED_WR(MASKED_WR)) u_regs (
    .cfg_clk (cfg_clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .gate_q  (gate_q)
  );

  assign sel   = ctrl_q[MUX_SHIFT +: MUX_W];
  assign n_cfg = ctrl_q[DIV_SHIFT +: DIV_W];

  hdiv_srcmux #(.NSRC(NSRC), .MUX_W(MUX_W)) u_mux (
    .src_clk (src_clk),
    .sel     (sel),
    .mux_clk (mux_clk)
  );

  hdiv_gate u_gate (
    .clk_in  (mux_clk),
    .rst_n   (rst_n),
    .en      (gate_q[GATE_BIT]),
    .clk_out (gclk)
  );

  hdiv_core #(.DIV_W(DIV_W)) u_core (
    .clk     (gclk),
    .rst_n   (rst_n),
    .n_cfg   (n_cfg),
    .div_clk (div_clk),
    .cnt_o   (core_cnt),
    .n_o     (core_n)
  );

endmodule

// File: rtl/hdiv_branch_chk.sv
`timescale 1ns/1ps
module hdiv_branch_chk #(
  parameter bit MASKED_WR = 1'b1,
  parameter int DIV_W     = 5
) (
  input logic             cfg_clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_addr,
  input logic [31:0]      wr_data,
  input logic [15:0]      ctrl_q,
  input logic [15:0]      gate_q,
  input logic             gclk,
  input logic [DIV_W+1:0] core_cnt,
  input logic [DIV_W-1:0] core_n
);

  localparam int CW = DIV_W + 2;

  generate
    if (MASKED_WR) begin : g_masked
      a_r2_mask_keeps_bits: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> (((ctrl_q ^ $past(ctrl_q)) & ~$past(wr_data[31:16])) == 16'h0));
    end else begin : g_plain
      a_r3_plain_replace: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> (ctrl_q == $past(wr_data[15:0])));
    end
  endgenerate

  a_r4_gate_write_spares_ctrl: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (wr_en && wr_addr) |=> $stable(ctrl_q));

  a_r4_ctrl_write_spares_gate: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (wr_en && !wr_addr) |=> $stable(gate_q));

  a_r10_idle_holds: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ctrl_q) && $stable(gate_q)));

  a_r5_count_in_frame: assert property (@(posedge gclk) disable iff (!rst_n)
    core_cnt <= (CW'({core_n, 1'b0}) + CW'(2)));

  a_r9_load_at_boundary: assert property (@(posedge gclk) disable iff (!rst_n)
    (core_n != $past(core_n)) |-> (core_cnt == '0));

endmodule

bind hdiv_branch hdiv_branch_chk #(.MASKED_WR(MASKED_WR), .DIV_W(DIV_W)) chk_i (
  .cfg_clk  (cfg_clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .ctrl_q   (ctrl_q),
  .gate_q   (gate_q),
  .gclk     (gclk),
  .core_cnt (core_cnt),
  .core_n   (core_n)
);

// File: tb/hdiv_branch_tb_top.sv
`timescale 1ns/1ps
module hdiv_branch_tb_top;

  logic cfg_clk = 1'b0;
  logic src0 = 1'b0;
  logic src1 = 1'b0;
  always #4 cfg_clk = ~cfg_clk;  // 125 MHz
  always #5 src0 = ~src0;        // half-period 5 ns
  always #7 src1 = ~src1;        // half-period 7 ns

  logic        rst_n;
  logic        wen_i, wad_i, wen_u, wad_u;
  logic [31:0] wdat_i, wdat_u;
  logic        dclk_i, dclk_u;
  logic [15:0] ctrl_i, gate_i, ctrl_u, gate_u;
  logic [15:0] mctrl_i, mgate_i, mctrl_u, mgate_u;

  int checks = 0;
  int errors = 0;
  int ecnt_i = 0;

  hdiv_branch #(.MASKED_WR(1'b1)) dut_i (
    .src_clk ({src1, src0}), .cfg_clk (cfg_clk), .rst_n (rst_n),
    .wr_en (wen_i), .wr_addr (wad_i), .wr_data (wdat_i),
    .div_clk (dclk_i), .ctrl_q (ctrl_i), .gate_q (gate_i));

  hdiv_branch #(.MASKED_WR(1'b0)) dut_u (
    .src_clk ({src1, src0}), .cfg_clk (cfg_clk), .rst_n (rst_n),
    .wr_en (wen_u), .wr_addr (wad_u), .wr_data (wdat_u),
    .div_clk (dclk_u), .ctrl_q (ctrl_u), .gate_q (gate_u));

  always @(posedge dclk_i) ecnt_i++;

  function automatic longint now_ps();
    return longint'($realtime * 1000.0);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_i(input logic a, input logic [31:0] d);
    @(negedge cfg_clk);
    wen_i = 1'b1; wad_i = a; wdat_i = d;
    @(negedge cfg_clk);
    wen_i = 1'b0;
    if (!a) mctrl_i = (mctrl_i & ~d[31:16]) | (d[15:0] & d[31:16]);
    else    mgate_i = (mgate_i & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  task automatic write_u(input logic a, input logic [31:0] d);
    @(negedge cfg_clk);
    wen_u = 1'b1; wad_u = a; wdat_u = d;
    @(negedge cfg_clk);
    wen_u = 1'b0;
    if (!a) mctrl_u = d[15:0];
    else    mgate_u = d[15:0];
  endtask

  // Two periods and one high phase after the settle interval.
  task automatic measure(input int n, input longint half, input string req);
    longint t0, t1, t2, t3;
    repeat (4) @(posedge dclk_i);
    @(posedge dclk_i); t0 = now_ps();
    @(negedge dclk_i); t1 = now_ps();
    @(posedge dclk_i); t2 = now_ps();
    @(posedge dclk_i); t3 = now_ps();
    check((t2 - t0) == (2 * n + 3) * half, req, "period A", t2 - t0, (2 * n + 3) * half);
    check((t3 - t2) == (2 * n + 3) * half, req, "period B", t3 - t2, (2 * n + 3) * half);
    check((t1 - t0) == (n + 1) * half, "R6", "high phase", t1 - t0, (n + 1) * half);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e0;
    longint tr, tf, tn, per, hi;
    rst_n = 1'b0;
    wen_i = 1'b0; wad_i = 1'b0; wdat_i = '0;
    wen_u = 1'b0; wad_u = 1'b0; wdat_u = '0;
    mctrl_i = '0; mgate_i = '0; mctrl_u = '0; mgate_u = '0;
    repeat (3) @(negedge cfg_clk);
    rst_n = 1'b1;

    // R1: reset state, no output edges while gated off
    e0 = ecnt_i;
    #300;
    check(ctrl_i == 16'h0, "R1", "ctrl masked", ctrl_i, 0);
    check(gate_i == 16'h0, "R1", "gate masked", gate_i, 0);
    check(ctrl_u == 16'h0 && gate_u == 16'h0, "R1", "plain regs", {ctrl_u, gate_u}, 0);
    check(ecnt_i == e0 && dclk_i == 1'b0, "R1", "edges", ecnt_i - e0, 0);

    // R2, R4: masked-write sweep
    for (int k = 0; k < 24; k++) begin
      logic [31:0] d;
      d = {16'(k * 40503 + 7), 16'((k * 21845) ^ (k * 257))};
      write_i(k[0] ^ k[2], d);
      check(ctrl_i == mctrl_i, k[0] ^ k[2] ? "R4" : "R2", "ctrl masked", ctrl_i, mctrl_i);
      check(gate_i == mgate_i, k[0] ^ k[2] ? "R2" : "R4", "gate masked", gate_i, mgate_i);
    end
    write_i(1'b0, {16'h0000, 16'hFFFF});
    check(ctrl_i == mctrl_i, "R2", "zero mask", ctrl_i, mctrl_i);

    // R3, R4: plain-write sweep
    for (int k = 0; k < 16; k++) begin
      logic [31:0] d;
      d = {16'(k * 4099 + 3), 16'(k * 30011 + 5)};
      write_u(k[1], d);
      check(ctrl_u == mctrl_u, k[1] ? "R4" : "R3", "ctrl plain", ctrl_u, mctrl_u);
      check(gate_u == mgate_u, k[1] ? "R3" : "R4", "gate plain", gate_u, mgate_u);
    end

    // R10: idle cycles leave registers alone
    repeat (5) @(negedge cfg_clk);
    check(ctrl_i == mctrl_i && gate_i == mgate_i, "R10", "idle masked", ctrl_i, mctrl_i);

    // R5, R6: every divide value on source 0
    write_i(1'b1, {16'hFFFF, 16'h0001});
    write_i(1'b0, {16'hFFFF, 16'h0000});
    for (int n = 0; n < 32; n++) begin
      write_i(1'b0, {16'h001F, 16'(n)});
      measure(n, 5000, "R5");
    end

    // R7: select source 1, then back to source 0
    write_i(1'b0, {16'hFFFF, 16'h0103});
    measure(3, 7000, "R7");
    write_i(1'b0, {16'h0100, 16'h0000});
    measure(3, 5000, "R7");

    // R8: gate off stops edges, gate on resumes
    write_i(1'b1, {16'h0001, 16'h0000});
    #300;
    e0 = ecnt_i;
    #600;
    check(ecnt_i == e0, "R8", "edges while off", ecnt_i - e0, 0);
    write_i(1'b1, {16'h0001, 16'h0001});
    #600;
    check(ecnt_i > e0, "R8", "edges after on", ecnt_i - e0, 1);
    measure(3, 5000, "R8");

    // R9: change N from 0 to 20 while running
    write_i(1'b0, {16'h001F, 16'h0000});
    repeat (6) @(posedge dclk_i);
    fork
      begin #40; write_i(1'b0, {16'h001F, 16'd20}); end
    join_none
    @(posedge dclk_i); tr = now_ps();
    per = 0;
    for (int j = 0; j < 12; j++) begin
      @(negedge dclk_i); tf = now_ps();
      @(posedge dclk_i); tn = now_ps();
      per = tn - tr; hi = tf - tr;
      check(per == 15000 || per == 215000, "R9", "period in change", per, 215000);
      check(hi == 5000 || hi == 105000, "R9", "high in change", hi, 105000);
      tr = tn;
    end
    check(per == 215000, "R9", "new ratio adopted", per, 215000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule